// File: doc/BRIEF.md
# Bit-Permutation Execute Unit

This unit executes three scalar bit-permutation operations for an integer pipeline. The operations are mirroring the bits inside each byte, spreading the two halves of a word across alternate bit positions (interleave), and gathering alternate bits back into the two halves (deinterleave). It takes the full 32-bit instruction word and the first source operand. It decodes the exact encoding, computes the destination value and flags any word it does not recognise as illegal.

Decode and permutation are purely combinational. A single register stage carries the result, the illegal flag and a valid bit to the output, so every accepted word gives its answer one clock later. The data width is a parameter that may be 32 or 64. Interleave and deinterleave are defined only for the 32-bit width. At 64 bits their encodings are reported as illegal.

Top module: `bitperm_unit`

## Requirements
- R1: An instruction with bits [6:0]=0010011, bits [14:12]=101 and bits [31:20]=011010000111 is a byte mirror. Result bit 8k+(7-j) equals operand bit 8k+j for every byte k of the word and every j in 0..7. It is legal at both widths.
- R2: An instruction with bits [6:0]=0010011, bits [14:12]=001 and bits [31:20]=000010001111 is an interleave at width 32. Result bit 2i equals operand bit i, and result bit 2i+1 equals operand bit i+16, for i in 0..15.
- R3: An instruction with bits [6:0]=0010011, bits [14:12]=101 and bits [31:20]=000010001111 is a deinterleave at width 32. Result bit i equals operand bit 2i, and result bit i+16 equals operand bit 2i+1. Deinterleaving an interleaved word returns the original word.
- R4: At width 64, the interleave and deinterleave encodings raise the illegal flag and give a zero result.
- R5: Any instruction word that matches none of the legal patterns raises the illegal flag and gives a zero result. A legal word clears the flag.
- R6: Bits [11:7] and [19:15] of the instruction have no effect on decode or result.
- R7: A cycle with in_valid high is followed in the next cycle by out_valid high, carrying that word's result and flag. A cycle with in_valid low is followed by out_valid low.
- R8: Synchronous active-high reset clears out_valid, out_result and out_illegal.
- R9: While in_valid is low, out_result and out_illegal keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction and operand are presented this cycle |
| in_instr | input | 32 | Full instruction word |
| in_rs1 | input | XLEN | First source operand |
| out_valid | output | 1 | Registered result is valid |
| out_result | output | XLEN | Registered destination value |
| out_illegal | output | 1 | Registered flag: instruction word not recognised |

## Verification
The bench builds two instances side by side, one with XLEN=32 and one with XLEN=64, and drives them with the same instruction stream. The 32-bit instance exercises the interleave and deinterleave networks and their inverse relation. The 64-bit instance exercises byte mirroring across eight bytes and the width gating that makes the shuffle encodings illegal. Walking-one operands map every single source bit to its destination. Flipping each decoded instruction bit one at a time covers every near miss of the three patterns, including the one-bit step from interleave to deinterleave.

// File: rtl/bitperm_pkg.sv
package bitperm_pkg;

    typedef enum logic [1:0] {
        PERM_NONE  = 2'd0,
        PERM_BREV  = 2'd1,
        PERM_ZIP   = 2'd2,
        PERM_UNZIP = 2'd3
    } perm_op_e;

    localparam logic [6:0]  OPC_OP_IMM   = 7'b0010011;
    localparam logic [11:0] IMM_BREV     = 12'b011010000111;
    localparam logic [11:0] IMM_SHUFFLE  = 12'b000010001111;
    localparam logic [2:0]  F3_BREV      = 3'b101;
    localparam logic [2:0]  F3_ZIP       = 3'b001;
    localparam logic [2:0]  F3_UNZIP     = 3'b101;

endpackage

// File: rtl/bitperm_decode.sv
module bitperm_decode
    import bitperm_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [31:0] instr,
    output perm_op_e    op
);

    localparam bit SHUFFLE_EN = (XLEN == 32);

    logic [6:0]  opcode_w;
    logic [2:0]  funct3_w;
    logic [11:0] imm_w;

    assign opcode_w = instr[6:0];
    assign funct3_w = instr[14:12];
    assign imm_w    = instr[31:20];

    always_comb begin
        op = PERM_NONE;
        if (opcode_w == OPC_OP_IMM) begin
            if (imm_w == IMM_BREV && funct3_w == F3_BREV) begin
                op = PERM_BREV;
            end else if (SHUFFLE_EN && imm_w == IMM_SHUFFLE) begin
                if (funct3_w == F3_ZIP) begin
                    op = PERM_ZIP;
                end else if (funct3_w == F3_UNZIP) begin
                    op = PERM_UNZIP;
                end
            end
        end
    end

    // R4: shuffle operations never decode on a wide datapath
    always_comb begin
        if (!SHUFFLE_EN) begin
            assert_wide_no_shuffle_R4: assert (op != PERM_ZIP && op != PERM_UNZIP);
        end
    end

    // R1: a recognised operation always carries the major opcode
    always_comb begin
        if (op != PERM_NONE) begin
            assert_opcode_match_R1: assert (instr[6:0] == OPC_OP_IMM);
        end
    end

endmodule

// File: rtl/bitperm_datapath.sv
module bitperm_datapath
    import bitperm_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  perm_op_e          op,
    input  logic [XLEN-1:0]   rs1,
    output logic [XLEN-1:0]   result
);

    localparam int NBYTES     = XLEN / 8;
    localparam int HALF       = XLEN / 2;
    localparam bit SHUFFLE_EN = (XLEN == 32);

    logic [XLEN-1:0] brev_w;
    logic [XLEN-1:0] zip_w;
    logic [XLEN-1:0] unzip_w;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        for (genvar j = 0; j < 8; j++) begin : g_bit
            assign brev_w[8*b + (7-j)] = rs1[8*b + j];
        end
    end

    if (SHUFFLE_EN) begin : g_shuffle
        for (genvar i = 0; i < HALF; i++) begin : g_pair
            assign zip_w[2*i]        = rs1[i];
            assign zip_w[2*i + 1]    = rs1[i + HALF];
            assign unzip_w[i]        = rs1[2*i];
            assign unzip_w[i + HALF] = rs1[2*i + 1];
        end
    end else begin : g_no_shuffle
        assign zip_w   = '0;
        assign unzip_w = '0;
    end

    always_comb begin
        unique case (op)
            PERM_BREV:  result = brev_w;
            PERM_ZIP:   result = zip_w;
            PERM_UNZIP: result = unzip_w;
            default:    result = '0;
        endcase
    end

    // R1: byte mirroring preserves the population count of the operand
    always_comb begin
        if (op == PERM_BREV) begin
            assert_brev_popcount_R1: assert ($countones(result) == $countones(rs1));
        end
    end

endmodule

// File: rtl/bitperm_unit.sv
module bitperm_unit
    import bitperm_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [31:0]       in_instr,
    input  logic [XLEN-1:0]   in_rs1,
    output logic              out_valid,
    output logic [XLEN-1:0]   out_result,
    output logic              out_illegal
);

    typedef struct packed {
        logic            valid;
        logic            illegal;
        logic [XLEN-1:0] result;
    } stage_t;

    perm_op_e        op_w;
    logic [XLEN-1:0] perm_w;
    stage_t          stage_d;
    stage_t          stage_q;

    bitperm_decode #(.XLEN(XLEN)) u_decode (
        .instr (in_instr),
        .op    (op_w)
    );

    bitperm_datapath #(.XLEN(XLEN)) u_datapath (
        .op     (op_w),
        .rs1    (in_rs1),
        .result (perm_w)
    );

    always_comb begin
        stage_d       = stage_q;
        stage_d.valid = in_valid;
        if (in_valid) begin
            stage_d.illegal = (op_w == PERM_NONE);
            stage_d.result  = perm_w;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign out_valid   = stage_q.valid;
    assign out_result  = stage_q.result;
    assign out_illegal = stage_q.illegal;

    assert_pulse_follows_R7: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_follows_R7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_illegal_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_illegal) |-> (out_result == '0));

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !$past(rst)) |=> ($stable(out_result) && $stable(out_illegal)));

    assert_reset_clears_R8: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && !out_illegal && out_result == '0));

endmodule

// File: tb/bitperm_unit_test.sv
`timescale 1ns/1ps
module bitperm_unit_test;

    localparam logic [11:0] T_IMM_BREV = 12'b011010000111;
    localparam logic [11:0] T_IMM_SHF  = 12'b000010001111;
    localparam logic [6:0]  T_OPC      = 7'b0010011;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_instr = '0;
    logic [31:0] rs1_32 = '0;
    logic [63:0] rs1_64 = '0;
    logic        ov32, ov64, oi32, oi64;
    logic [31:0] or32;
    logic [63:0] or64;

    int vectors = 0;
    int fails   = 0;

    always #4 clk = ~clk;

    bitperm_unit #(.XLEN(32)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_instr(in_instr),
        .in_rs1(rs1_32), .out_valid(ov32), .out_result(or32), .out_illegal(oi32)
    );

    bitperm_unit #(.XLEN(64)) uut_w64 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_instr(in_instr),
        .in_rs1(rs1_64), .out_valid(ov64), .out_result(or64), .out_illegal(oi64)
    );

    function automatic logic [31:0] mk(logic [11:0] imm, logic [2:0] f3,
                                       logic [4:0] rd, logic [4:0] rs);
        return {imm, rs, f3, rd, T_OPC};
    endfunction

    // returns {illegal, result}, computed from the requirement text
    function automatic logic [64:0] model(logic [31:0] ins, logic [63:0] a, int xl);
        logic [63:0] r = '0;
        int half = xl / 2;
        bit is_op  = (ins[6:0] == T_OPC);
        bit brev   = is_op && ins[31:20] == T_IMM_BREV && ins[14:12] == 3'd5;
        bit zip    = is_op && xl == 32 && ins[31:20] == T_IMM_SHF && ins[14:12] == 3'd1;
        bit unzip  = is_op && xl == 32 && ins[31:20] == T_IMM_SHF && ins[14:12] == 3'd5;
        for (int p = 0; p < xl; p++) begin
            if (brev)  r[p] = a[(p / 8) * 8 + 7 - (p % 8)];
            if (zip)   r[p] = (p % 2 == 0) ? a[p / 2] : a[p / 2 + half];
            if (unzip) r[p] = (p < half) ? a[2 * p] : a[2 * (p - half) + 1];
        end
        return {!(brev || zip || unzip), r};
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(logic [31:0] ins, logic [63:0] a, string req);
        logic [64:0] e32, e64;
        @(negedge clk);
        in_valid = 1'b1; in_instr = ins; rs1_32 = a[31:0]; rs1_64 = a;
        @(negedge clk);
        in_valid = 1'b0;
        e32 = model(ins, {32'b0, a[31:0]}, 32);
        e64 = model(ins, a, 64);
        vectors++;
        check(ov32 == 1'b1, {req, " R7 valid32"}, {63'b0, ov32}, 64'd1);
        check(or32 == e32[31:0], {req, " result32"}, {32'b0, or32}, {32'b0, e32[31:0]});
        check(oi32 == e32[64], {req, " R5 illegal32"}, {63'b0, oi32}, {63'b0, e32[64]});
        check(ov64 == 1'b1, {req, " R7 valid64"}, {63'b0, ov64}, 64'd1);
        check(or64 == e64[63:0], {req, " result64"}, or64, e64[63:0]);
        check(oi64 == e64[64], {req, " R4 illegal64"}, {63'b0, oi64}, {63'b0, e64[64]});
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
        $finish;
    end

    initial begin
        logic [31:0] ops [3];
        logic [31:0] keep32;
        logic [63:0] keep64;
        ops[0] = mk(T_IMM_BREV, 3'd5, 5'd1, 5'd2);
        ops[1] = mk(T_IMM_SHF,  3'd1, 5'd3, 5'd4);
        ops[2] = mk(T_IMM_SHF,  3'd5, 5'd5, 5'd6);

        // R8: reset state
        repeat (3) @(negedge clk);
        vectors++;
        check(!ov32 && !oi32 && or32 == 0, "R8 reset32", {31'b0, ov32, oi32, or32}, 64'd0);
        check(!ov64 && !oi64 && or64 == 0, "R8 reset64", {62'b0, ov64, oi64}, 64'd0);
        rst = 1'b0;

        // R1 R2 R3 R4: walking ones map every source bit
        for (int i = 0; i < 64; i++) begin
            apply(ops[0], 64'd1 << i, "R1 walk");
            apply(ops[1], 64'd1 << i, "R2 walk");
            apply(ops[2], 64'd1 << i, "R3 walk");
        end

        // R6: random operands with random register fields
        for (int n = 0; n < 150; n++) begin
            logic [4:0] rd = 5'($urandom);
            logic [4:0] rs = 5'($urandom);
            logic [63:0] a = {$urandom, $urandom};
            apply(mk(T_IMM_BREV, 3'd5, rd, rs), a, "R1 R6 random");
            apply(mk(T_IMM_SHF,  3'd1, rd, rs), a, "R2 R6 random");
            apply(mk(T_IMM_SHF,  3'd5, rd, rs), a, "R3 R6 random");
        end

        // R5: every single-bit near miss of each decoded field
        for (int k = 0; k < 3; k++) begin
            for (int b = 0; b < 32; b++) begin
                if (!((b >= 7 && b <= 11) || (b >= 15 && b <= 19))) begin
                    apply(ops[k] ^ (32'd1 << b), 64'hF0E1_D2C3_B4A5_9687, "R5 flip");
                end
            end
        end
        apply(32'h0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, "R5 zero word");
        apply(32'hFFFF_FFFF, 64'h1234_5678_9ABC_DEF0, "R5 ones word");

        // R3: deinterleave undoes interleave at width 32
        for (int n = 0; n < 40; n++) begin
            logic [31:0] x = $urandom;
            apply(ops[1], {32'b0, x}, "R2 pre-inverse");
            keep32 = or32;
            apply(ops[2], {32'b0, keep32}, "R3 inverse step");
            vectors++;
            check(or32 == x, "R3 inverse", {32'b0, or32}, {32'b0, x});
        end

        // R9 R7: idle cycle holds result, drops valid
        apply(ops[0], 64'h0102_0408_1020_4080, "R1 pre-hold");
        keep32 = or32; keep64 = or64;
        in_instr = 32'hFFFF_FFFF; rs1_32 = 32'h5555_5555; rs1_64 = '1;
        @(negedge clk);
        vectors++;
        check(!ov32 && !ov64, "R7 idle valid", {62'b0, ov32, ov64}, 64'd0);
        check(or32 == keep32 && !oi32, "R9 hold32", {32'b0, or32}, {32'b0, keep32});
        check(or64 == keep64 && !oi64, "R9 hold64", or64, keep64);

        // R8: reset after activity clears outputs
        apply(32'hDEAD_BEEF, 64'd7, "R5 pre-reset");
        rst = 1'b1;
        @(negedge clk);
        vectors++;
        check(!ov32 && !oi32 && or32 == 0, "R8 mid reset32", {31'b0, ov32, oi32, or32}, 64'd0);
        check(!ov64 && !oi64 && or64 == 0, "R8 mid reset64", or64, 64'd0);
        rst = 1'b0;

        report();
        $finish;
    end

endmodule